// File: doc/BRIEF.md
# Serial SPI EEPROM Slave Interface

This block makes a byte-addressed register array answer on an SPI bus the way a small serial EEPROM does. A master selects it with an active-low select and clocks in an instruction byte, an address byte and, for writes, one or more data bytes. Clock modes 0 and 3 are accepted. The block samples input bits on rising clock edges and changes its output after falling clock edges. The select, clock and data-in pins are brought into the system clock domain through synchronizer stages, and edges are detected there. For this reason the system clock must run several times faster than the serial clock.

Reads stream without limit. The byte address counts up after every byte and wraps from the top of the array back to zero. Writes collect up to one 16-byte page. A self-timed programming period follows, counted in system clock cycles, and the page is copied into the array when that period ends. An external protection block decides whether a page may be programmed. The slave presents the page base address and the current protection level, and it samples a single grant input when select rises. The array holds `2**ADDR_W` bytes, with `ADDR_W` set to 7, 8 or 9. Address bits above that width are dropped. The serial link has no back-pressure: the master paces every transfer, and the slave always keeps up within one clock half-period.

Top module: `spi_ee_slave`

## Requirements
- R1: Input bits are taken MSB first on rising serial clock edges. Each output bit is presented MSB first after a falling edge, so a mode 0 master and a mode 3 master read the same bytes.
- R2: `spi_miso_oe` is 0 whenever select is high, and it is 0 after reset. A command is accepted only after select has gone from high to low after reset. If select is held low through reset, the bytes clocked in that period are ignored.
- R3: The read instruction is `0000_A011`, where bit 3 (A) carries address bit 8. It is followed by address bits 7..0. Data then appears on `spi_miso` starting at that address.
- R4: During a read, the address advances by one after each byte and wraps from the top of the array to address 0. Clocking may continue until select rises.
- R5: A read started while a programming period runs is refused. `spi_miso_oe` stays 0 for the rest of that select period.
- R6: Instruction 0x06 sets the write-enable flag and 0x04 clears it. Bit 3 of every instruction is ignored when decoding.
- R7: Instruction 0x05 returns the status byte and keeps repeating it for as long as clocking continues. In the status byte, bit 0 is the busy flag, bit 1 is the write-enable flag, bits 3:2 are the protection level, and all other bits are 0.
- R8: The write instruction is `0000_A010`, followed by address bits 7..0 and then data bytes. It is accepted only when the write-enable flag is set. Successive bytes increment only the low 4 address bits, so they wrap within the 16-byte page.
- R9: Programming starts when select rises, but only if three conditions hold: at least one whole data byte was received, the bit count is a multiple of 8, and `prot_grant` is 1. The busy flag then stays set for `PROG_CYCLES` cycles, and the written bytes can be read after it clears.
- R10: The write-enable flag clears when select rises at the end of a write (once its address has been taken) or a status write. This happens whether or not programming starts.
- R11: The status write instruction 0x01 is followed by one byte whose bits 3:2 become the protection level. The level changes, and a busy period starts, only if select rises after exactly 16 bits.
- R12: Instructions that decode to none of the six codes are ignored until select rises. They leave the output off and all state unchanged.
- R13: While busy, only the status read is served. Any other instruction, including 0x06, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select from the master |
| spi_sck | input | 1 | Serial clock, mode 0 or mode 3 |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, valid while `spi_miso_oe` is 1 |
| spi_miso_oe | output | 1 | Output enable for the data-out pad driver |
| prot_page_addr | output | ADDR_W | Base address of the page being written |
| prot_level | output | 2 | Current protection level from the status byte |
| prot_grant | input | 1 | 1 when the protection block allows programming of `prot_page_addr` |

## Verification
On every cycle, the assertions check four things. The output is off shortly after select goes high. Every busy period lasts exactly `PROG_CYCLES` cycles. A busy period only ever begins when the write-enable flag was set, and it leaves that flag cleared. While busy, the output is driven only for a status read. The values themselves can only be shown by the bench's scenarios: the streamed data and its address wrap, in-page wrap of write data, refusal of a write for lack of enable, grant, byte alignment or data, the 16-bit rule for status writes, and identical results in both clock modes.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  // Controller phase within one select period
  typedef enum logic [2:0] {
    ST_IDLE,   // not selected, or not armed since reset
    ST_CMD,    // collecting the instruction byte
    ST_ADDR,   // collecting the low address byte
    ST_READ,   // streaming array data out
    ST_WRITE,  // collecting page data
    ST_RDSR,   // streaming the status byte out
    ST_WRSR,   // collecting the new status byte
    ST_DROP    // ignoring the bus until select rises
  } ee_state_t;

  // Instruction codes with bit 3 cleared; bit 3 is masked before compare
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WREN  = 8'h06;

  localparam logic [7:0] OPC_MASK  = 8'hF7;

  function automatic logic op_is(input logic [7:0] op, input logic [7:0] code);
    return (op & OPC_MASK) == code;
  endfunction

endpackage

// File: rtl/spi_ee_frontend.sv
// Brings select, clock and data-in into the system clock domain, finds
// serial clock edges while selected and assembles received bytes.
module spi_ee_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       sel_start,
  output logic       sel_end,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       aligned
);

  logic [SYNC_STAGES-1:0] cs_sr, sck_sr, mosi_sr;
  logic sel, sel_d, sck_s, sck_d, mosi_s;
  logic [2:0] bit_cnt;

  // Select chain resets to "selected" so that a select held low through
  // reset never looks like a fresh falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr   <= '0;
      sck_sr  <= '0;
      mosi_sr <= '0;
    end else begin
      cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      sck_sr  <= {sck_sr[SYNC_STAGES-2:0], sck};
      mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
    end
  end

  assign sel    = ~cs_sr[SYNC_STAGES-1];
  assign sck_s  = sck_sr[SYNC_STAGES-1];
  assign mosi_s = mosi_sr[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      sel_d <= sel;
      sck_d <= sck_s;
    end
  end

  assign sel_start = sel & ~sel_d;
  assign sel_end   = ~sel & sel_d;
  assign sck_rise  = sel & sck_s & ~sck_d;
  assign sck_fall  = sel & ~sck_s & sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sel_start) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        rx_byte   <= {rx_byte[6:0], mosi_s};
        bit_cnt   <= bit_cnt + 3'd1;
        byte_done <= (bit_cnt == 3'd7);
      end
    end
  end

  assign aligned = (bit_cnt == 3'd0);

endmodule

// File: rtl/spi_ee_page_buf.sv
// One page of pending write data with a per-byte valid mask.
module spi_ee_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        wr_en,
  input  logic [PW-1:0]               wr_idx,
  input  logic [7:0]                  wr_data,
  output logic [PAGE_BYTES-1:0][7:0]  data,
  output logic [PAGE_BYTES-1:0]       valid,
  output logic                        any
);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[g] <= 1'b0;
        data[g]  <= '0;
      end else if (clear) begin
        valid[g] <= 1'b0;
      end else if (wr_en && (wr_idx == PW'(g))) begin
        valid[g] <= 1'b1;
        data[g]  <= wr_data;
      end
    end
  end

  assign any = |valid;

endmodule

// File: rtl/spi_ee_busy_timer.sv
// Self-timed programming period: busy for exactly CYCLES clocks.
module spi_ee_busy_timer #(
  parameter int CYCLES = 256,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (remain == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          remain <= remain - CW'(1);
        end
      end else if (start) begin
        busy   <= 1'b1;
        remain <= CW'(CYCLES - 1);
      end
    end
  end

endmodule

// File: rtl/spi_ee_slave.sv
// Serial EEPROM style slave: instruction decode, address capture, read
// streaming, page write buffering and busy reporting.
module spi_ee_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PROG_CYCLES = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] prot_page_addr,
  output logic [1:0]        prot_level,
  input  logic              prot_grant
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 16;
  localparam int PW         = $clog2(PAGE_BYTES);
  localparam int PGW        = ADDR_W - PW;

  // front end
  logic       sel_start, sel_end, sck_rise, sck_fall, byte_done, aligned;
  logic [7:0] rx_byte;

  spi_ee_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_fe (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (spi_cs_n),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .sel_start (sel_start),
    .sel_end   (sel_end),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .aligned   (aligned)
  );

  // controller state
  ee_state_t         state;
  logic              sess;
  logic [7:0]        opcode;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        byte_cnt;
  logic              wel_q;
  logic [1:0]        level_q;
  logic [1:0]        wrsr_lvl;
  logic [7:0]        tx_sr;
  logic              miso_q;
  logic              oe_q;
  logic [PGW-1:0]    wr_page;
  logic [PW-1:0]     wr_idx;
  logic              prog_wr;

  // array
  logic [7:0] mem [DEPTH];

  // page buffer and timer
  logic                       pb_clear, pb_wr, pb_any;
  logic [PAGE_BYTES-1:0][7:0] pb_data;
  logic [PAGE_BYTES-1:0]      pb_valid;
  logic                       busy, tmr_done, tmr_start;
  logic                       write_go, wrsr_go;

  // address formed from instruction bit 3 and the address byte
  logic [8:0]        full_addr;
  logic [ADDR_W-1:0] byte_addr;
  logic [7:0]        status;
  logic              in_rdsr;

  assign full_addr = {opcode[3], rx_byte};
  assign byte_addr = full_addr[ADDR_W-1:0];
  assign status    = {4'b0000, level_q, wel_q, busy};
  assign in_rdsr   = (state == ST_RDSR);

  assign pb_clear = sess && byte_done && (state == ST_ADDR) && !op_is(opcode, OPC_READ);
  assign pb_wr    = sess && byte_done && (state == ST_WRITE);

  spi_ee_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (pb_clear),
    .wr_en   (pb_wr),
    .wr_idx  (wr_idx),
    .wr_data (rx_byte),
    .data    (pb_data),
    .valid   (pb_valid),
    .any     (pb_any)
  );

  // programming starts only at a byte-aligned deselect
  assign write_go  = sess && sel_end && (state == ST_WRITE) && aligned && pb_any && prot_grant;
  assign wrsr_go   = sess && sel_end && (state == ST_WRSR) && aligned && (byte_cnt == 2'd2);
  assign tmr_start = write_go || wrsr_go;

  spi_ee_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .busy  (busy),
    .done  (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sess     <= 1'b0;
      opcode   <= '0;
      addr_q   <= '0;
      byte_cnt <= '0;
      wel_q    <= 1'b0;
      level_q  <= '0;
      wrsr_lvl <= '0;
      tx_sr    <= '0;
      miso_q   <= 1'b0;
      oe_q     <= 1'b0;
      wr_page  <= '0;
      wr_idx   <= '0;
      prog_wr  <= 1'b0;
    end else begin
      if (tmr_start) prog_wr <= write_go;

      if (sel_end) begin
        sess  <= 1'b0;
        oe_q  <= 1'b0;
        state <= ST_IDLE;
        if (sess && (state == ST_WRITE || state == ST_WRSR)) wel_q <= 1'b0;
        if (wrsr_go) level_q <= wrsr_lvl;
      end else if (sel_start) begin
        sess     <= 1'b1;
        state    <= ST_CMD;
        byte_cnt <= '0;
        oe_q     <= 1'b0;
      end else if (sess) begin
        if (byte_done) begin
          if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
          case (state)
            ST_CMD: begin
              opcode <= rx_byte;
              if (busy) begin
                // only the status read is served while programming
                if (op_is(rx_byte, OPC_RDSR)) begin
                  state <= ST_RDSR;
                  tx_sr <= status;
                  oe_q  <= 1'b1;
                end else begin
                  state <= ST_DROP;
                end
              end else if (op_is(rx_byte, OPC_READ)) begin
                state <= ST_ADDR;
              end else if (op_is(rx_byte, OPC_WRITE)) begin
                state <= wel_q ? ST_ADDR : ST_DROP;
              end else if (op_is(rx_byte, OPC_WREN)) begin
                wel_q <= 1'b1;
                state <= ST_DROP;
              end else if (op_is(rx_byte, OPC_WRDI)) begin
                wel_q <= 1'b0;
                state <= ST_DROP;
              end else if (op_is(rx_byte, OPC_RDSR)) begin
                state <= ST_RDSR;
                tx_sr <= status;
                oe_q  <= 1'b1;
              end else if (op_is(rx_byte, OPC_WRSR)) begin
                state <= wel_q ? ST_WRSR : ST_DROP;
              end else begin
                state <= ST_DROP;
              end
            end
            ST_ADDR: begin
              if (op_is(opcode, OPC_READ)) begin
                state  <= ST_READ;
                tx_sr  <= mem[byte_addr];
                addr_q <= byte_addr + ADDR_W'(1);
                oe_q   <= 1'b1;
              end else begin
                state   <= ST_WRITE;
                wr_page <= byte_addr[ADDR_W-1:PW];
                wr_idx  <= byte_addr[PW-1:0];
              end
            end
            ST_READ: begin
              tx_sr  <= mem[addr_q];
              addr_q <= addr_q + ADDR_W'(1);
            end
            ST_RDSR:  tx_sr <= status;
            ST_WRITE: wr_idx <= wr_idx + PW'(1);
            ST_WRSR:  wrsr_lvl <= rx_byte[3:2];
            default: ;
          endcase
        end else if (sck_fall && oe_q) begin
          miso_q <= tx_sr[7];
          tx_sr  <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  // array: erased at reset, page copied in when the busy period ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (tmr_done && prog_wr) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pb_valid[i]) mem[{wr_page, PW'(i)}] <= pb_data[i];
      end
    end
  end

  assign spi_miso       = miso_q;
  assign spi_miso_oe    = oe_q;
  assign prot_page_addr = {wr_page, {PW{1'b0}}};
  assign prot_level     = level_q;

endmodule

// File: rtl/spi_ee_slave_chk.sv
module spi_ee_slave_chk #(
  parameter int PROG_CYCLES = 256
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic oe,
  input logic busy,
  input logic wel,
  input logic in_rdsr
);

  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else run_len <= 0;
  end

  // R2: output released once select has been high a few cycles
  a_r2_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !oe);

  // R9: every busy period lasts exactly PROG_CYCLES cycles
  a_r9_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == PROG_CYCLES));

  // R8: programming never starts without the write-enable flag
  a_r8_busy_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R10: the write-enable flag is clear once programming starts
  a_r10_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wel);

  // R13: while busy, the output is driven only for a status read
  a_r13_busy_status_only: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && oe) |-> in_rdsr);

endmodule

bind spi_ee_slave spi_ee_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (spi_cs_n),
  .oe      (spi_miso_oe),
  .busy    (busy),
  .wel     (wel_q),
  .in_rdsr (in_rdsr)
);

// File: tb/tb_spi_ee_slave.sv
module tb_spi_ee_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int AW         = 9;
  localparam int PROG       = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, prot_grant;
  logic [AW-1:0] prot_page_addr;
  logic [1:0] prot_level;
  logic mode3 = 1'b0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [8:0] exp_q[$];
  logic [8:0] act_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ee_slave #(.ADDR_W(AW), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .prot_page_addr(prot_page_addr),
    .prot_level(prot_level), .prot_grant(prot_grant)
  );

  // protection model: level 1 guards the upper quarter, 2 the upper half, 3 all
  always_comb begin
    case (prot_level)
      2'd0: prot_grant = 1'b1;
      2'd1: prot_grant = (prot_page_addr < 9'h180);
      2'd2: prot_grant = (prot_page_addr < 9'h100);
      default: prot_grant = 1'b0;
    endcase
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares produced bytes against expectations in order
  always @(negedge clk) begin
    if (act_q.size() != 0) begin
      logic [8:0] a;
      a = act_q.pop_front();
      if (exp_q.size() == 0) check("unexpected", {23'd0, a}, 32'hFFFF_FFFF);
      else check(tag_q.pop_front(), {23'd0, a}, {23'd0, exp_q.pop_front()});
    end
  end

  task automatic expect_byte(input string req, input logic [7:0] v);
    exp_q.push_back({1'b1, v});
    tag_q.push_back(req);
  endtask

  task automatic spi_begin();
    @(negedge clk);
    sck = mode3;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic spi_end();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic spi_shift(input logic [7:0] tx, input int nbits,
                           output logic [7:0] rx, output logic oe_any, output logic oe_all);
    rx = '0; oe_any = 1'b0; oe_all = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      if (mode3) sck = 1'b0;
      mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[6:0], miso};
      oe_any = oe_any | miso_oe;
      oe_all = oe_all & miso_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r; logic a, b;
    spi_begin();
    spi_shift(op, 8, r, a, b);
    spi_end();
  endtask

  task automatic rd_status(input string req, input logic [7:0] v);
    logic [7:0] r; logic a, b;
    expect_byte(req, v);
    spi_begin();
    spi_shift(8'h05, 8, r, a, b);
    spi_shift(8'h00, 8, r, a, b);
    act_q.push_back({b, r});
    spi_end();
  endtask

  task automatic read_stream(input logic [7:0] op, input logic [7:0] adr, input int n);
    logic [7:0] r; logic a, b;
    spi_begin();
    spi_shift(op, 8, r, a, b);
    spi_shift(adr, 8, r, a, b);
    for (int i = 0; i < n; i++) begin
      spi_shift(8'h00, 8, r, a, b);
      act_q.push_back({b, r});
    end
    spi_end();
  endtask

  task automatic write_bytes(input logic [7:0] op, input logic [7:0] adr,
                             input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input int n, input int extra);
    logic [7:0] r; logic a, b;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    spi_begin();
    spi_shift(op, 8, r, a, b);
    spi_shift(adr, 8, r, a, b);
    for (int i = 0; i < n; i++) spi_shift(d[i], 8, r, a, b);
    if (extra > 0) spi_shift(8'hA5, extra, r, a, b);
    spi_end();
  endtask

  task automatic wrsr(input logic [7:0] v, input int extra);
    logic [7:0] r; logic a, b;
    spi_begin();
    spi_shift(8'h01, 8, r, a, b);
    spi_shift(v, 8, r, a, b);
    if (extra > 0) spi_shift(8'h00, extra, r, a, b);
    spi_end();
  endtask

  task automatic wait_prog();
    repeat (PROG + 50) @(negedge clk);
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
    check("scoreboard_drained", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r; logic oa, ob;
    // R2: select held low across reset, bytes clocked then are ignored
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 reset oe", miso_oe, 0);
    spi_shift(8'h06, 8, r, oa, ob);
    check("R2 no output while unarmed", oa, 0);
    spi_end();
    rd_status("R2 wel untouched without select fall", 8'h00);
    rd_status("R7 reset status", 8'h00);

    // R3 R1: erased array in mode 0 and mode 3
    expect_byte("R3 read erased", 8'hFF);
    read_stream(8'h03, 8'h00, 1);
    mode3 = 1'b1;
    expect_byte("R1 mode3 read erased", 8'hFF);
    read_stream(8'h03, 8'h40, 1);
    mode3 = 1'b0;

    // R6: enable/disable, bit 3 ignored
    cmd(8'h06);
    rd_status("R6 wren sets wel", 8'h02);
    cmd(8'h0C);
    rd_status("R6 wrdi with bit3 clears wel", 8'h00);
    cmd(8'h0E);
    rd_status("R6 wren with bit3 sets wel", 8'h02);

    // R8 R9: page write at 0x1FE wraps inside the page to 0x1F0
    write_bytes(8'h0A, 8'hFE, 8'hA1, 8'hA2, 8'hA3, 3, 0);
    rd_status("R7 R10 busy and wel cleared", 8'h01);
    // R5: read during busy refused
    spi_begin();
    spi_shift(8'h0B, 8, r, oa, ob);
    spi_shift(8'hFE, 8, r, oa, ob);
    spi_shift(8'h00, 8, r, oa, ob);
    check("R5 read refused while busy", oa, 0);
    spi_end();
    cmd(8'h06); // R13: ignored while busy
    wait_prog();
    rd_status("R13 wren during busy ignored", 8'h00);
    // R4: stream across the top of the array
    expect_byte("R8 byte at 1FE", 8'hA1);
    expect_byte("R4 byte at 1FF", 8'hA2);
    expect_byte("R4 wrap to 000", 8'hFF);
    read_stream(8'h0B, 8'hFE, 3);
    mode3 = 1'b1;
    expect_byte("R8 page wrap at 1F0", 8'hA3);
    expect_byte("R1 R4 mode3 next byte", 8'hFF);
    read_stream(8'h0B, 8'hF0, 2);
    mode3 = 1'b0;
    drain();

    // R8: write without enable ignored
    write_bytes(8'h02, 8'h20, 8'h44, 8'h00, 8'h00, 1, 0);
    rd_status("R8 no busy without wel", 8'h00);
    expect_byte("R8 array unchanged", 8'hFF);
    read_stream(8'h03, 8'h20, 1);

    // R9: unaligned end aborts
    cmd(8'h06);
    write_bytes(8'h02, 8'h10, 8'h55, 8'h00, 8'h00, 1, 3);
    rd_status("R9 R10 unaligned no busy, wel cleared", 8'h00);
    expect_byte("R9 unaligned not written", 8'hFF);
    read_stream(8'h03, 8'h10, 1);

    // R9: no data bytes
    cmd(8'h06);
    write_bytes(8'h02, 8'h30, 8'h00, 8'h00, 8'h00, 0, 0);
    rd_status("R9 empty write no busy", 8'h00);

    // R11: status write sets level 3
    cmd(8'h06);
    wrsr(8'h0C, 0);
    rd_status("R11 level set and busy", 8'h0D);
    wait_prog();
    rd_status("R11 level after busy", 8'h0C);
    // R9: grant denied
    cmd(8'h06);
    write_bytes(8'h02, 8'h00, 8'h11, 8'h00, 8'h00, 1, 0);
    rd_status("R9 denied no busy", 8'h0C);
    expect_byte("R9 denied not written", 8'hFF);
    read_stream(8'h03, 8'h00, 1);
    // level 1: upper quarter guarded
    cmd(8'h06);
    wrsr(8'h04, 0);
    wait_prog();
    rd_status("R11 level 1", 8'h04);
    cmd(8'h06);
    write_bytes(8'h0A, 8'h00, 8'h22, 8'h00, 8'h00, 1, 0);
    wait_prog();
    cmd(8'h06);
    write_bytes(8'h0A, 8'h80, 8'h33, 8'h00, 8'h00, 1, 0);
    rd_status("R9 guarded page no busy", 8'h04);
    expect_byte("R9 granted write 100", 8'h22);
    expect_byte("R4 next after 100", 8'hFF);
    read_stream(8'h0B, 8'h00, 2);
    expect_byte("R9 guarded 180 unchanged", 8'hFF);
    read_stream(8'h0B, 8'h80, 1);
    // R11: 17 bits do not apply
    cmd(8'h06);
    wrsr(8'h00, 1);
    rd_status("R11 17 bits ignored", 8'h04);

    // R12: unknown instruction
    cmd(8'h06);
    spi_begin();
    spi_shift(8'hFF, 8, r, oa, ob);
    spi_shift(8'h12, 8, r, oa, ob);
    check("R12 unknown opcode no output", oa, 0);
    spi_end();
    rd_status("R12 state unchanged", 8'h06);

    // R2: output off after deselect
    repeat (5) @(negedge clk);
    check("R2 oe off when deselected", miso_oe, 0);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule